// File: doc/BRIEF.md
# Signed-Magnitude Sequential Divider

This block divides a double-width signed-magnitude dividend by a single-width signed-magnitude divisor, one quotient bit per clock. The dividend's upper half is loaded into a partial-remainder register and its lower half into a quotient register; the divisor sits in a third register and never moves. In each step the remainder and quotient registers shift left together, bringing the next dividend bit into the remainder. A trial subtraction, made by adding the two's complement of the divisor, then decides the step. Its end carry, together with the bit shifted out of the remainder, tells whether the trial difference is kept. The result of that decision becomes the new quotient bit.

Before any step runs, the dividend's upper half is compared with the divisor. If it is not smaller, the quotient cannot fit in the result width. In that case the block raises an overflow flag and finishes on the spot, and a zero divisor always ends up here. Otherwise a step counter loaded with the width runs the block through exactly that many steps and then pulses done. The signs are handled apart from the magnitudes: the quotient is negative when the operand signs differ, and the remainder takes the sign of the dividend.

Top module: `sm_div_top`

## Requirements
- R1: While reset is held and after its release, busy, done, ovf, quo_mag, rem_mag, quo_sign and rem_sign are all 0.
- R2: When start is accepted and the upper W bits of dvd_mag are greater than or equal to dvs_mag, ovf and done both go to 1 after that same clock edge and no division steps run.
- R3: A divisor magnitude of 0 always gives ovf = 1, whatever the dividend is.
- R4: When no overflow occurs, done comes with quo_mag = dvd_mag / dvs_mag and rem_mag = dvd_mag mod dvs_mag, both as unsigned integers, and rem_mag is below the divisor.
- R5: After an accepted start, quo_sign equals dvd_sign XOR dvs_sign and rem_sign equals dvd_sign.
- R6: done is a single-cycle pulse and is never high together with busy. Without overflow, it goes high after the W+1-th rising edge counted from the edge that accepts start. With overflow, it goes high after the accepting edge itself.
- R7: start is accepted only while busy is 0. A start raised while busy is high changes neither the results nor the signs, and it produces no extra done.
- R8: Once done has pulsed, quo_mag, rem_mag, quo_sign, rem_sign and ovf hold their values until the next accepted start. An accepted start clears ovf unless the new operands overflow again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division, sampled while idle |
| dvd_sign | input | 1 | Dividend sign, 1 means negative |
| dvd_mag | input | 2*W | Dividend magnitude |
| dvs_sign | input | 1 | Divisor sign, 1 means negative |
| dvs_mag | input | W | Divisor magnitude |
| busy | output | 1 | High while division steps are running |
| done | output | 1 | One-cycle pulse when a result or an overflow is ready |
| ovf | output | 1 | Divide overflow, held until the next accepted start |
| quo_mag | output | W | Quotient magnitude |
| quo_sign | output | 1 | Quotient sign |
| rem_mag | output | W | Remainder magnitude |
| rem_sign | output | 1 | Remainder sign |

## Verification
The bench builds the divider with W = 8, which makes the step count and the full operand range small. With that width, the corner cases are easy to hit on purpose: the largest quotient 0xFF, a dividend upper half exactly equal to the divisor, a zero divisor, a divisor of 1, a zero dividend and exact division. At that width, randomized operands in which the upper half stays below the divisor also cover many different remainder paths. All four sign combinations, a start raised in the middle of a run, and the eight-step-plus-one latency are all checked at the ports.

// File: rtl/sm_div_pkg.sv
package sm_div_pkg;
  // Controller state: idle waits for start, run performs one step per clock.
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/sm_div_step.sv
// One restoring-division step: shift E:A:Q left, trial-subtract B from A,
// keep the difference when the shifted-out bit or the end carry is set.
module sm_div_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] q_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] q_out,
  output logic         qbit
);
  localparam int SW = W + 1;

  // Adds x to the two's complement of y; bit W is the end carry.
  function automatic logic [SW-1:0] add_twos(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, ~y} + {{W{1'b0}}, 1'b1};
  endfunction

  logic          shift_e;
  logic [W-1:0]  shift_a;
  logic [SW-1:0] trial;

  always_comb begin
    shift_e = a_in[W-1];
    shift_a = {a_in[W-2:0], q_in[W-1]};
    trial   = add_twos(shift_a, b_in);
    qbit    = shift_e | trial[W];
    // Restoring B to a failed difference gives shift_a back, so select it directly.
    a_out   = qbit ? trial[W-1:0] : shift_a;
    q_out   = {q_in[W-2:0], qbit};
  end
endmodule

// File: rtl/sm_div_seq.sv
// Step counter: loaded with the step count, counts down once per step.
module sm_div_seq #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic last
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] STEPS = CW'(W);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] sc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sc_q <= '0;
    else if (load)    sc_q <= STEPS;
    else if (step)    sc_q <= sc_q - ONE;
  end

  assign last = (sc_q == ONE);
endmodule

// File: rtl/sm_div_top.sv
module sm_div_top #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           dvd_sign,
  input  logic [2*W-1:0] dvd_mag,
  input  logic           dvs_sign,
  input  logic [W-1:0]   dvs_mag,
  output logic           busy,
  output logic           done,
  output logic           ovf,
  output logic [W-1:0]   quo_mag,
  output logic           quo_sign,
  output logic [W-1:0]   rem_mag,
  output logic           rem_sign
);
  import sm_div_pkg::*;

  div_state_e   state_q;
  logic [W-1:0] a_q, q_q, b_q;
  logic         as_q, bs_q, ovf_q, done_q;

  // Named internal events, visible to the checker.
  logic         accept;
  logic         ovf_detect;
  logic         step_en;
  logic         step_last;
  logic         step_qbit;
  logic [W-1:0] step_a, step_q;

  assign accept     = (state_q == ST_IDLE) && start;
  assign ovf_detect = (dvd_mag[2*W-1:W] >= dvs_mag);
  assign step_en    = (state_q == ST_RUN);

  sm_div_step #(.W(W)) step_i (
    .a_in (a_q),
    .q_in (q_q),
    .b_in (b_q),
    .a_out(step_a),
    .q_out(step_q),
    .qbit (step_qbit)
  );

  sm_div_seq #(.W(W)) seq_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept && !ovf_detect),
    .step (step_en),
    .last (step_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      q_q     <= '0;
      b_q     <= '0;
      as_q    <= 1'b0;
      bs_q    <= 1'b0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        a_q     <= dvd_mag[2*W-1:W];
        q_q     <= dvd_mag[W-1:0];
        b_q     <= dvs_mag;
        as_q    <= dvd_sign;
        bs_q    <= dvs_sign;
        ovf_q   <= ovf_detect;
        done_q  <= ovf_detect;
        state_q <= ovf_detect ? ST_IDLE : ST_RUN;
      end else if (step_en) begin
        a_q <= step_a;
        q_q <= step_q;
        if (step_last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign busy     = step_en;
  assign done     = done_q;
  assign ovf      = ovf_q;
  assign quo_mag  = q_q;
  assign rem_mag  = a_q;
  assign quo_sign = as_q ^ bs_q;
  assign rem_sign = as_q;
endmodule

// File: rtl/sm_div_chk.sv
module sm_div_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         ovf,
  input logic [W-1:0] quo_mag,
  input logic [W-1:0] rem_mag,
  input logic         quo_sign,
  input logic         rem_sign,
  input logic [W-1:0] divisor
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_OVF_ENDS_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> done); // R2
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && divisor == '0) |-> ovf); // R3
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovf) |-> (rem_mag < divisor)); // R4
  AST_SIGNS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(quo_sign) && $stable(rem_sign))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quo_mag) && $stable(rem_mag) && $stable(ovf))); // R8
endmodule

bind sm_div_top sm_div_chk #(.W(W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .ovf     (ovf),
  .quo_mag (quo_mag),
  .rem_mag (rem_mag),
  .quo_sign(quo_sign),
  .rem_sign(rem_sign),
  .divisor (b_q)
);

// File: tb/sm_div_top_tb_top.sv
module sm_div_top_tb_top;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           dvd_sign = 1'b0;
  logic [2*W-1:0] dvd_mag = '0;
  logic           dvs_sign = 1'b0;
  logic [W-1:0]   dvs_mag = '0;
  logic           busy, done, ovf, quo_sign, rem_sign;
  logic [W-1:0]   quo_mag, rem_mag;

  sm_div_top #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dvd_sign(dvd_sign), .dvd_mag(dvd_mag),
    .dvs_sign(dvs_sign), .dvs_mag(dvs_mag),
    .busy(busy), .done(done), .ovf(ovf),
    .quo_mag(quo_mag), .quo_sign(quo_sign),
    .rem_mag(rem_mag), .rem_sign(rem_sign)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic         ovf;
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         qs;
    logic         rs;
    int           due;
  } exp_t;

  exp_t expq[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the oldest expected item whenever done is seen.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) begin
        check(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(cyc == e.due, "R6 done latency", cyc, e.due);
        check(ovf == e.ovf, "R2/R3 ovf flag", ovf, e.ovf);
        if (!e.ovf) begin
          check(quo_mag == e.q, "R4 quotient", quo_mag, e.q);
          check(rem_mag == e.r, "R4 remainder", rem_mag, e.r);
        end
        check(quo_sign == e.qs, "R5 quotient sign", quo_sign, e.qs);
        check(rem_sign == e.rs, "R5 remainder sign", rem_sign, e.rs);
      end
    end
  end

  // Driver: computes the expected result, pushes it, then drives one start.
  task automatic run_div(input logic sa, input logic [2*W-1:0] a,
                         input logic sb, input logic [W-1:0] b, input bit poke_busy);
    exp_t e;
    logic [W-1:0] hq, hr;
    logic hqs, hrs, hov;
    @(negedge clk);
    e.ovf = (b == '0) || ((a >> W) >= {{W{1'b0}}, b});
    if (!e.ovf) begin
      e.q = W'(a / {{W{1'b0}}, b});
      e.r = W'(a % {{W{1'b0}}, b});
    end else begin
      e.q = '0;
      e.r = '0;
    end
    e.qs  = sa ^ sb;
    e.rs  = sa;
    e.due = cyc + 1 + (e.ovf ? 0 : W);
    expq.push_back(e);
    start = 1'b1; dvd_sign = sa; dvd_mag = a; dvs_sign = sb; dvs_mag = b;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      // R7: a start during the run with other operands must be ignored.
      @(negedge clk);
      check(busy == 1'b1, "R7 busy during run", busy, 1);
      start = 1'b1; dvd_sign = ~sa; dvd_mag = 16'h0101; dvs_sign = ~sb; dvs_mag = 8'h03;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    hq = quo_mag; hr = rem_mag; hqs = quo_sign; hrs = rem_sign; hov = ovf;
    @(negedge clk);
    check(done == 1'b0, "R6 done single pulse", done, 0);
    repeat (3) @(negedge clk);
    check({quo_mag, rem_mag, quo_sign, rem_sign, ovf} == {hq, hr, hqs, hrs, hov},
          "R8 results held", {quo_mag, rem_mag, quo_sign, rem_sign, ovf},
          {hq, hr, hqs, hrs, hov});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset and just after release
    check({busy, done, ovf, quo_mag, rem_mag, quo_sign, rem_sign} == '0,
          "R1 reset held", {busy, done, ovf, quo_mag, rem_mag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, ovf, quo_mag, rem_mag, quo_sign, rem_sign} == '0,
          "R1 after release", {busy, done, ovf, quo_mag, rem_mag}, 0);

    run_div(1'b0, 16'h1234, 1'b0, 8'h56, 1'b0);  // R4 ordinary
    run_div(1'b0, 16'h7FFF, 1'b0, 8'h80, 1'b0);  // R4 largest quotient
    run_div(1'b0, 16'h3000, 1'b0, 8'h30, 1'b0);  // R2 upper half equals divisor
    run_div(1'b1, 16'h0000, 1'b0, 8'h00, 1'b0);  // R3 zero divisor
    run_div(1'b1, 16'h00AB, 1'b0, 8'h01, 1'b0);  // R4 divide by one, R5 signs
    run_div(1'b0, 16'h0000, 1'b1, 8'h07, 1'b0);  // R4 zero dividend, R5
    run_div(1'b1, 16'h0C00, 1'b1, 8'h20, 1'b0);  // R4 exact, R5 both negative
    run_div(1'b0, 16'hFE01, 1'b0, 8'hFF, 1'b0);  // R4 shifted-out bit path
    run_div(1'b1, 16'h4567, 1'b0, 8'h9A, 1'b1);  // R7 start while busy
    run_div(1'b0, 16'h9000, 1'b1, 8'h10, 1'b0);  // R2 overflow, then R8 clears below
    run_div(1'b0, 16'h0010, 1'b0, 8'h10, 1'b0);  // R8 ovf cleared by next start
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] b, hi, lo;
      b  = W'($urandom_range(1, (1 << W) - 1));
      hi = W'($urandom_range(0, b - 1));
      lo = W'($urandom);
      run_div(1'($urandom), {hi, lo}, 1'($urandom), b, (i % 5) == 0); // R4 R5 random
    end
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R6 every start completed", expq.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<50000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule